// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard control logic of a five-stage in-order integer pipeline (IF, ID, EX, MEM, WB), with a pipeline register between each pair of stages. It looks at source register numbers in ID and EX. It also looks at the destination numbers, write enables and load flags held in the ID/EX, EX/MEM and MEM/WB registers, and at the branch decision made in ID. From these it produces operand bypass selects and the hold, bubble and flush controls that keep dependent instructions correct.

The ALU in EX can take either operand from the EX/MEM result or from the MEM/WB result instead of the register file. Branches compare registers and compute their target in ID, so the two comparator operands get the same kind of bypass. Some results do not exist yet when they are needed: a load result needed by the very next instruction, or an ALU or load result needed by a branch in ID. In those cases the unit holds PC and IF/ID and turns the ID/EX slot into a bubble. Fetch runs as if every branch falls through. When a branch in ID resolves taken, the unit flushes the one instruction fetched behind it.

The unit is purely combinational. Every output reflects the inputs of the same cycle.

Top module: `hzd_unit`

## Requirements
- R1: For each EX operand (`ex_rs`, `ex_rt`), the select is 1 (EX/MEM result) when `mem_wen` is 1, `mem_load` is 0, `mem_rd` is nonzero and `mem_rd` equals that source.
- R2: If R1 does not hold for an EX operand, its select is 2 (MEM/WB result) when `wb_wen` is 1, `wb_rd` is nonzero and `wb_rd` equals the source. Otherwise the select is 0 (register file).
- R3: When the EX/MEM and MEM/WB destinations both match a source, the select is 1. The nearer result wins.
- R4: Register 0 never counts as a match, for forwarding or for stalling. A write enable of 0 also never counts as a match. Select value 3 never occurs.
- R5: Load-use stall. It applies when `ex_load` and `ex_wen` are 1, `ex_rd` is nonzero, and `ex_rd` equals `id_rs` or `id_rt`. Then `pc_hold`, `ifid_hold` and `idex_bubble` are all 1.
- R6: Branch-after-ALU stall. It applies when `id_branch` is 1, and an instruction in EX with `ex_wen`=1 and `ex_load`=0 writes a nonzero `id_rs` or `id_rt`. Then the three stall outputs are 1. This costs one cycle.
- R7: Branch-after-load stall. The three stall outputs are 1 when `id_branch` is 1 and either condition holds:
  - a load in EX (`ex_load`, `ex_wen`) writes a nonzero branch source, or
  - a load in MEM (`mem_load`, `mem_wen`) writes a nonzero branch source.
  A load right before a branch therefore stalls it for two cycles.
- R8: The ID comparator selects `br_a_sel` (for `id_rs`) and `br_b_sel` (for `id_rt`) follow the same rules as R1 to R4, with the same encoding.
- R9: `ifid_flush` is 1 exactly when `id_branch` and `id_taken` are 1 and no stall is raised in that cycle.
- R10: With no hazard condition present, `pc_hold`, `ifid_hold`, `idex_bubble` and `ifid_flush` are 0. The three stall outputs are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | First source register of the instruction in ID |
| id_rt | input | 5 | Second source register of the instruction in ID |
| id_branch | input | 1 | Instruction in ID is a conditional branch |
| id_taken | input | 1 | Branch comparator in ID finds the branch taken |
| ex_rs | input | 5 | First source register of the instruction in EX |
| ex_rt | input | 5 | Second source register of the instruction in EX |
| ex_rd | input | 5 | Destination register held in ID/EX |
| ex_wen | input | 1 | Instruction in EX writes the register file |
| ex_load | input | 1 | Instruction in EX is a load |
| mem_rd | input | 5 | Destination register held in EX/MEM |
| mem_wen | input | 1 | Instruction in MEM writes the register file |
| mem_load | input | 1 | Instruction in MEM is a load |
| wb_rd | input | 5 | Destination register held in MEM/WB |
| wb_wen | input | 1 | Instruction in WB writes the register file |
| fwd_a_sel | output | 2 | ALU operand A source: 0 register file, 1 EX/MEM, 2 MEM/WB |
| fwd_b_sel | output | 2 | ALU operand B source, same encoding |
| br_a_sel | output | 2 | Branch comparator operand A source, same encoding |
| br_b_sel | output | 2 | Branch comparator operand B source, same encoding |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the IF/ID register unchanged this cycle |
| idex_bubble | output | 1 | Zero the control fields entering ID/EX |
| ifid_flush | output | 1 | Clear the wrongly fetched instruction in IF/ID |

## Verification
The tests walk the unit through short instruction sequences, one pipeline step at a time.

- An add followed by a dependent sub, at distance one and then two, shows whether the EX/MEM and MEM/WB paths each fire. A case where both destinations match the source shows the priority between them.
- A load followed by a dependent add is followed through its bubble and its later MEM/WB bypass. This separates the load-use stall from ordinary forwarding.
- Branches that depend on an ALU result or on a load show a one-cycle stall versus a two-cycle stall, followed by the comparator bypass.
- Taken branches with and without a pending stall show that the flush is gated by the stall.
- Register 0 cases and write-enable-low cases show that no false match is made.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Operand source for a bypass mux
    typedef enum logic [1:0] {
        SRC_RF   = 2'd0,
        SRC_NEAR = 2'd1,
        SRC_FAR  = 2'd2
    } byp_src_e;

    // Reasons for holding the front of the pipeline
    typedef struct packed {
        logic load_use;
        logic br_alu;
        logic br_load;
    } stall_why_t;

    function automatic logic stall_any(input stall_why_t w);
        return w.load_use | w.br_alu | w.br_load;
    endfunction

endpackage

// File: rtl/hzd_bypass_pick.sv
module hzd_bypass_pick
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] near_rd,
    input  logic             near_wen,
    input  logic             near_load,
    input  logic [REG_W-1:0] far_rd,
    input  logic             far_wen,
    output byp_src_e         sel
);
    logic near_hit;
    logic far_hit;

    // A load result is not in EX/MEM yet, so the nearer path skips it
    assign near_hit = near_wen && !near_load && (near_rd != '0) && (near_rd == src);
    assign far_hit  = far_wen && (far_rd != '0) && (far_rd == src);

    always_comb begin
        if (near_hit)     sel = SRC_NEAR;
        else if (far_hit) sel = SRC_FAR;
        else              sel = SRC_RF;
    end
endmodule

// File: rtl/hzd_stall_detect.sv
module hzd_stall_detect
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_branch,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wen,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic             mem_load,
    output stall_why_t       why
);
    logic ex_dep;
    logic mem_dep;

    assign ex_dep  = ex_wen && (ex_rd != '0) && ((ex_rd == id_rs) || (ex_rd == id_rt));
    assign mem_dep = mem_wen && (mem_rd != '0) && ((mem_rd == id_rs) || (mem_rd == id_rt));

    always_comb begin
        why          = '0;
        why.load_use = ex_dep && ex_load;
        why.br_alu   = id_branch && ex_dep && !ex_load;
        why.br_load  = id_branch && ((ex_dep && ex_load) || (mem_dep && mem_load));
    end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_branch,
    input  logic             id_taken,
    input  logic [REG_W-1:0] ex_rs,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wen,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic             mem_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wen,
    output logic [1:0]       fwd_a_sel,
    output logic [1:0]       fwd_b_sel,
    output logic [1:0]       br_a_sel,
    output logic [1:0]       br_b_sel,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble,
    output logic             ifid_flush
);
    localparam int N_OPND = 4;

    logic [REG_W-1:0] opnd_src [N_OPND];
    byp_src_e         opnd_sel [N_OPND];
    stall_why_t       why;
    logic             stall;

    // Operand order: ALU A, ALU B, comparator A, comparator B
    assign opnd_src[0] = ex_rs;
    assign opnd_src[1] = ex_rt;
    assign opnd_src[2] = id_rs;
    assign opnd_src[3] = id_rt;

    for (genvar g = 0; g < N_OPND; g++) begin : g_byp
        hzd_bypass_pick #(.REG_W(REG_W)) u_pick (
            .src       (opnd_src[g]),
            .near_rd   (mem_rd),
            .near_wen  (mem_wen),
            .near_load (mem_load),
            .far_rd    (wb_rd),
            .far_wen   (wb_wen),
            .sel       (opnd_sel[g])
        );
    end

    hzd_stall_detect #(.REG_W(REG_W)) u_stall (
        .id_rs     (id_rs),
        .id_rt     (id_rt),
        .id_branch (id_branch),
        .ex_rd     (ex_rd),
        .ex_wen    (ex_wen),
        .ex_load   (ex_load),
        .mem_rd    (mem_rd),
        .mem_wen   (mem_wen),
        .mem_load  (mem_load),
        .why       (why)
    );

    assign stall       = stall_any(why);
    assign fwd_a_sel   = opnd_sel[0];
    assign fwd_b_sel   = opnd_sel[1];
    assign br_a_sel    = opnd_sel[2];
    assign br_b_sel    = opnd_sel[3];
    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;
    assign ifid_flush  = id_branch && id_taken && !stall;
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] ex_rs,
    input logic [REG_W-1:0] ex_rt,
    input logic [REG_W-1:0] id_rs,
    input logic [REG_W-1:0] id_rt,
    input logic             id_branch,
    input logic             id_taken,
    input logic             mem_wen,
    input logic             mem_load,
    input logic             wb_wen,
    input logic             ex_wen,
    input logic [1:0]       fwd_a_sel,
    input logic [1:0]       fwd_b_sel,
    input logic [1:0]       br_a_sel,
    input logic [1:0]       br_b_sel,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             idex_bubble,
    input logic             ifid_flush
);
    always_comb begin
        // R10: the three stall outputs from separate paths agree
        assert_hold_agree_R10: assert ((pc_hold == ifid_hold) && (ifid_hold == idex_bubble));
        // R9: a flush is never issued while the front is held
        assert_flush_gated_R9: assert (!(ifid_flush && pc_hold));
        // R9: a flush requires a taken branch
        assert_flush_cause_R9: assert (!ifid_flush || (id_branch && id_taken));
        // R4: no register-0 match and no code 3 on the ALU selects
        assert_alu_r0_R4: assert (((fwd_a_sel == 2'd0) || (ex_rs != '0)) &&
                                  ((fwd_b_sel == 2'd0) || (ex_rt != '0)) &&
                                  (fwd_a_sel != 2'd3) && (fwd_b_sel != 2'd3));
        // R8: same register-0 rule on comparator selects
        assert_br_r0_R8: assert (((br_a_sel == 2'd0) || (id_rs != '0)) &&
                                 ((br_b_sel == 2'd0) || (id_rt != '0)) &&
                                 (br_a_sel != 2'd3) && (br_b_sel != 2'd3));
        // R1: the nearer path is only used for a non-load writer
        assert_near_src_R1: assert (((fwd_a_sel != 2'd1) && (fwd_b_sel != 2'd1)) ||
                                    (mem_wen && !mem_load));
        // R2: the farther path needs a writing instruction in WB
        assert_far_src_R2: assert (((fwd_a_sel != 2'd2) && (fwd_b_sel != 2'd2)) || wb_wen);
        // R5: a stall needs a writer in EX or MEM
        assert_stall_src_R5: assert (!pc_hold || ex_wen || mem_wen);
    end
endmodule

bind hzd_unit hzd_unit_chk #(.REG_W(REG_W)) u_chk (
    .ex_rs       (ex_rs),
    .ex_rt       (ex_rt),
    .id_rs       (id_rs),
    .id_rt       (id_rt),
    .id_branch   (id_branch),
    .id_taken    (id_taken),
    .mem_wen     (mem_wen),
    .mem_load    (mem_load),
    .wb_wen      (wb_wen),
    .ex_wen      (ex_wen),
    .fwd_a_sel   (fwd_a_sel),
    .fwd_b_sel   (fwd_b_sel),
    .br_a_sel    (br_a_sel),
    .br_b_sel    (br_b_sel),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble),
    .ifid_flush  (ifid_flush)
);

// File: tb/hzd_unit_bench.sv
`timescale 1ns/1ps
module hzd_unit_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
    logic id_branch, id_taken, ex_wen, ex_load, mem_wen, mem_load, wb_wen;
    logic [1:0] fwd_a_sel, fwd_b_sel, br_a_sel, br_b_sel;
    logic pc_hold, ifid_hold, idex_bubble, ifid_flush;

    int total = 0;
    int bad = 0;
    bit done = 0;

    hzd_unit u_hzd_unit (
        .id_rs(id_rs), .id_rt(id_rt), .id_branch(id_branch), .id_taken(id_taken),
        .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
        .wb_rd(wb_rd), .wb_wen(wb_wen),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .br_a_sel(br_a_sel), .br_b_sel(br_b_sel),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold),
        .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic clear_all();
        id_rs = 0; id_rt = 0; id_branch = 0; id_taken = 0;
        ex_rs = 0; ex_rt = 0; ex_rd = 0; ex_wen = 0; ex_load = 0;
        mem_rd = 0; mem_wen = 0; mem_load = 0; wb_rd = 0; wb_wen = 0;
    endtask

    task automatic step_begin();
        @(negedge clk);
        clear_all();
    endtask

    task automatic look(input string tag, input int fa, input int fb, input int ba,
                        input int bb, input int st, input int fl);
        #2;
        chk({tag, " fwd_a"}, fwd_a_sel, fa);
        chk({tag, " fwd_b"}, fwd_b_sel, fb);
        chk({tag, " br_a"}, br_a_sel, ba);
        chk({tag, " br_b"}, br_b_sel, bb);
        chk({tag, " pc_hold R10"}, pc_hold, st);
        chk({tag, " ifid_hold R10"}, ifid_hold, st);
        chk({tag, " idex_bubble R10"}, idex_bubble, st);
        chk({tag, " flush R9"}, ifid_flush, fl);
    endtask

    task automatic t_idle();
        step_begin();
        look("R10 idle", 0, 0, 0, 0, 0, 0);
    endtask

    // add r8 <- ..., then sub uses r8 at distance 1 and 2
    task automatic t_add_sub();
        step_begin();
        ex_rs = 8; ex_rt = 2; mem_rd = 8; mem_wen = 1;
        look("R1 add-sub near", 1, 0, 0, 0, 0, 0);
        step_begin();
        ex_rs = 3; ex_rt = 8; wb_rd = 8; wb_wen = 1;
        look("R2 add-sub far", 0, 2, 0, 0, 0, 0);
    endtask

    task automatic t_priority();
        step_begin();
        ex_rs = 9; ex_rt = 9; mem_rd = 9; mem_wen = 1; wb_rd = 9; wb_wen = 1;
        look("R3 both match", 1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_reg_zero();
        step_begin();
        ex_rs = 0; ex_rt = 0; mem_rd = 0; mem_wen = 1; wb_rd = 0; wb_wen = 1;
        look("R4 reg zero fwd", 0, 0, 0, 0, 0, 0);
        step_begin();
        ex_rs = 6; mem_rd = 6; mem_wen = 0; wb_rd = 6; wb_wen = 0;
        look("R4 wen low", 0, 0, 0, 0, 0, 0);
        step_begin();
        id_branch = 1; id_rs = 0; ex_rd = 0; ex_wen = 1; ex_load = 1;
        look("R4 reg zero stall", 0, 0, 0, 0, 0, 0);
    endtask

    // lw r5; add uses r5
    task automatic t_load_use();
        step_begin();
        id_rs = 1; id_rt = 5; ex_rd = 5; ex_wen = 1; ex_load = 1;
        look("R5 load-use", 0, 0, 0, 0, 1, 0);
        step_begin();
        id_rs = 1; id_rt = 5; mem_rd = 5; mem_wen = 1; mem_load = 1;
        look("R5 after bubble", 0, 0, 0, 0, 0, 0);
        step_begin();
        ex_rs = 1; ex_rt = 5; wb_rd = 5; wb_wen = 1;
        look("R2 load result far", 0, 2, 0, 0, 0, 0);
        step_begin();
        id_rs = 7; id_rt = 4; ex_rd = 5; ex_wen = 1; ex_load = 1;
        look("R5 no match", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_branch_alu();
        step_begin();
        id_branch = 1; id_taken = 1; id_rs = 3; id_rt = 2; ex_rd = 3; ex_wen = 1;
        look("R6 br-alu stall", 0, 0, 0, 0, 1, 0);
        step_begin();
        id_branch = 1; id_taken = 1; id_rs = 3; id_rt = 2; mem_rd = 3; mem_wen = 1;
        look("R8 br near", 0, 0, 1, 0, 0, 1);
    endtask

    task automatic t_branch_load();
        step_begin();
        id_branch = 1; id_rs = 2; id_rt = 4; ex_rd = 4; ex_wen = 1; ex_load = 1;
        look("R7 br-load cycle1", 0, 0, 0, 0, 1, 0);
        step_begin();
        id_branch = 1; id_rs = 2; id_rt = 4; mem_rd = 4; mem_wen = 1; mem_load = 1;
        look("R7 br-load cycle2", 0, 0, 0, 0, 1, 0);
        step_begin();
        id_branch = 1; id_rs = 2; id_rt = 4; wb_rd = 4; wb_wen = 1;
        look("R8 br far", 0, 0, 0, 2, 0, 0);
    endtask

    task automatic t_flush();
        step_begin();
        id_branch = 1; id_taken = 1; id_rs = 10; id_rt = 11;
        look("R9 taken no hazard", 0, 0, 0, 0, 0, 1);
        step_begin();
        id_branch = 0; id_taken = 1;
        look("R9 taken not branch", 0, 0, 0, 0, 0, 0);
        step_begin();
        id_branch = 1; id_taken = 1; id_rs = 12; id_rt = 12;
        mem_rd = 12; mem_wen = 1; wb_rd = 12; wb_wen = 1;
        look("R8 br priority", 0, 0, 1, 1, 0, 1);
    endtask

    initial begin
        clear_all();
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_add_sub();
        t_priority();
        t_reg_zero();
        t_load_use();
        t_branch_alu();
        t_branch_load();
        t_flush();
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog got=0 exp=1");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule